// File: doc/BRIEF.md
# Reconfiguration Port Register Bridge

This block sits between a processor's simple register bus and the 16-bit dynamic reconfiguration port of a clock synthesizer. Two plain configuration registers drive the synthesizer's reset-release and enable lines and its clock-source selection. Software reads or writes one synthesizer register by writing a single command word. That write launches one complete port cycle on its own.

Completion is reported through a separate status word. Software polls its busy flag until it clears, both before it issues a command and after a read. When busy is clear, the low half of the status word holds the data returned by the most recent port read. A command written while a cycle is still in flight is dropped, and the cycle already running is left untouched.

Top module: `cfgport_bridge`

## Requirements
- R1: After reset, every listed register reads zero, the busy flag is clear, the reset-release, synthesizer-enable and source-select outputs are zero, and no port enable is driven.
- R2: The register at byte offset 0x40 keeps bits 1:0 of a write and reads them back, with all other bits reading zero. Bit 0 drives the reset-release output and bit 1 drives the synthesizer-enable output.
- R3: The register at byte offset 0x44 reads back all 32 bits exactly as written and drives the source-select output.
- R4: A write to byte offset 0x70 while idle, with bit 29 set, produces exactly one single-cycle port enable in the cycle after the bus write. The port address is taken from bits 22:16 and the port write data from bits 15:0. Bit 28 selects the direction: 1 is a read, 0 is a write. The port write enable is high in the enable cycle only for a write.
- R5: Status bit 16 (busy) at byte offset 0x74 is set from the cycle after an accepted command. It stays set until the port ready is sampled and clears one cycle later. For a reply that arrives L cycles after the enable cycle, busy reads high on exactly L+2 consecutive cycles.
- R6: On the ready of a port read, status bits 15:0 take the port read data. A port write and any cycle without ready leave these bits unchanged.
- R7: A command written to offset 0x70 while busy is set is ignored. It causes no further enable, and the port address and write data stay steady until the cycle in flight ends.
- R8: A write to offset 0x70 with bit 29 clear starts no port cycle and leaves the command readback unchanged.
- R9: Any byte offset other than 0x40, 0x44, 0x70 and 0x74 reads zero, and a write to it changes no register and starts no port cycle.
- R10: Offset 0x70 reads back the last accepted command. Bit 29 is set once a command has been accepted, and bits 28, 22:16 and 15:0 carry its direction, address and data. All other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr_i | input | BUS_AW | Register byte offset |
| bus_wr_i | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| blk_rel_o | output | 1 | Reset-release enable (offset 0x40 bit 0) |
| synth_en_o | output | 1 | Synthesizer enable (offset 0x40 bit 1) |
| src_sel_o | output | SRC_W | Clock-source selection value |
| prt_addr_o | output | 7 | Port register address |
| prt_wdata_o | output | 16 | Port write data |
| prt_rdata_i | input | 16 | Port read data, valid with prt_rdy_i |
| prt_en_o | output | 1 | Port enable, one-cycle pulse per transaction |
| prt_we_o | output | 1 | Port write enable, high with prt_en_o for writes |
| prt_rdy_i | input | 1 | Port completion pulse |

## Verification
The assertions assume that the port answers every enable with exactly one ready pulse, that the pulse comes at least one cycle after the enable, and that no ready arrives while the bridge is idle. The bench port model enforces this by construction. It records each enable and answers it once, after a programmable delay of one or more cycles. It never raises ready on its own. The bus stimulus changes only on the falling clock edge, so the address and write strobe are steady at every rising edge the bridge samples.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

  // fixed geometry of the reconfiguration port and the bus word
  localparam int unsigned PORT_AW = 7;
  localparam int unsigned PORT_DW = 16;
  localparam int unsigned WORD_W  = 32;

  // register byte offsets (software relies on these)
  localparam logic [7:0] OFS_RSTCTL = 8'h40;
  localparam logic [7:0] OFS_SRCSEL = 8'h44;
  localparam logic [7:0] OFS_PCMD   = 8'h70;
  localparam logic [7:0] OFS_PSTAT  = 8'h74;

  // command and status field positions
  localparam int unsigned CMD_GO_BIT    = 29;
  localparam int unsigned CMD_RD_BIT    = 28;
  localparam int unsigned CMD_ADDR_LSB  = 16;
  localparam int unsigned STAT_BUSY_BIT = 16;
  localparam int unsigned RSTCTL_W      = 2;

  typedef enum logic [1:0] {
    XS_IDLE  = 2'd0,
    XS_ISSUE = 2'd1,
    XS_WAIT  = 2'd2
  } xact_state_e;

  typedef struct packed {
    logic               rd;
    logic [PORT_AW-1:0] addr;
    logic [PORT_DW-1:0] data;
  } port_cmd_t;

endpackage

// File: rtl/cfgport_cfgregs.sv
module cfgport_cfgregs
  import cfgport_pkg::*;
#(
  parameter int unsigned BUS_AW = 8,
  parameter int unsigned SRC_W  = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic [BUS_AW-1:0]   addr_i,
  input  logic [WORD_W-1:0]   wdata_i,
  output logic [RSTCTL_W-1:0] rstctl_o,
  output logic [SRC_W-1:0]    srcsel_o
);

  localparam logic [BUS_AW-1:0] A_RST = BUS_AW'(OFS_RSTCTL);
  localparam logic [BUS_AW-1:0] A_SEL = BUS_AW'(OFS_SRCSEL);

  logic                rst_en;
  logic [RSTCTL_W-1:0] rst_d, rst_q;
  logic                sel_en;
  logic [SRC_W-1:0]    sel_d, sel_q;

  // next-state
  always_comb begin
    rst_en = wr_i && (addr_i == A_RST);
    rst_d  = wdata_i[RSTCTL_W-1:0];
    sel_en = wr_i && (addr_i == A_SEL);
    sel_d  = wdata_i[SRC_W-1:0];
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q <= '0;
    end else if (rst_en) begin
      rst_q <= rst_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
    end else if (sel_en) begin
      sel_q <= sel_d;
    end
  end

  assign rstctl_o = rst_q;
  assign srcsel_o = sel_q;

endmodule

// File: rtl/cfgport_cmdreg.sv
module cfgport_cmdreg
  import cfgport_pkg::*;
#(
  parameter int unsigned BUS_AW = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [BUS_AW-1:0]  addr_i,
  input  logic               go_i,
  input  logic               rd_i,
  input  logic [PORT_AW-1:0] paddr_i,
  input  logic [PORT_DW-1:0] pdata_i,
  input  logic               busy_i,
  output logic               launch_o,
  output port_cmd_t          cmd_o,
  output logic [WORD_W-1:0]  cmd_word_o
);

  localparam logic [BUS_AW-1:0] A_CMD = BUS_AW'(OFS_PCMD);

  logic      accept;
  port_cmd_t cmd_d, cmd_q;
  logic      seen_q;

  // a command is taken only when addressed, armed and the port is free
  always_comb begin
    accept     = wr_i && (addr_i == A_CMD) && go_i && !busy_i;
    cmd_d.rd   = rd_i;
    cmd_d.addr = paddr_i;
    cmd_d.data = pdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      seen_q <= 1'b0;
    end else if (accept) begin
      cmd_q  <= cmd_d;
      seen_q <= 1'b1;
    end
  end

  always_comb begin
    cmd_word_o                               = '0;
    cmd_word_o[CMD_GO_BIT]                   = seen_q;
    cmd_word_o[CMD_RD_BIT]                   = cmd_q.rd;
    cmd_word_o[CMD_ADDR_LSB +: PORT_AW]      = cmd_q.addr;
    cmd_word_o[PORT_DW-1:0]                  = cmd_q.data;
  end

  assign launch_o = accept;
  assign cmd_o    = cmd_q;

endmodule

// File: rtl/cfgport_xact.sv
module cfgport_xact
  import cfgport_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               launch_i,
  input  logic               rd_i,
  input  logic               prt_rdy_i,
  input  logic [PORT_DW-1:0] prt_rdata_i,
  output logic               busy_o,
  output logic               prt_en_o,
  output logic               prt_we_o,
  output logic [PORT_DW-1:0] rdata_o
);

  xact_state_e        state_d, state_q;
  logic               cap_en;
  logic [PORT_DW-1:0] rdata_q;

  // next-state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      XS_IDLE:  if (launch_i) state_d = XS_ISSUE;
      XS_ISSUE: state_d = prt_rdy_i ? XS_IDLE : XS_WAIT;
      XS_WAIT:  if (prt_rdy_i) state_d = XS_IDLE;
      default:  state_d = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= XS_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign busy_o   = (state_q != XS_IDLE);
  assign prt_en_o = (state_q == XS_ISSUE);
  assign prt_we_o = prt_en_o && !rd_i;

  // read data is taken only on the completion of a read
  assign cap_en = busy_o && prt_rdy_i && rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (cap_en) begin
      rdata_q <= prt_rdata_i;
    end
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/cfgport_bridge.sv
module cfgport_bridge
  import cfgport_pkg::*;
#(
  parameter int unsigned BUS_AW = 8,
  parameter int unsigned SRC_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [BUS_AW-1:0]  bus_addr_i,
  input  logic               bus_wr_i,
  input  logic [WORD_W-1:0]  bus_wdata_i,
  output logic [WORD_W-1:0]  bus_rdata_o,
  output logic               blk_rel_o,
  output logic               synth_en_o,
  output logic [SRC_W-1:0]   src_sel_o,
  output logic [PORT_AW-1:0] prt_addr_o,
  output logic [PORT_DW-1:0] prt_wdata_o,
  input  logic [PORT_DW-1:0] prt_rdata_i,
  output logic               prt_en_o,
  output logic               prt_we_o,
  input  logic               prt_rdy_i
);

  localparam logic [BUS_AW-1:0] A_RST  = BUS_AW'(OFS_RSTCTL);
  localparam logic [BUS_AW-1:0] A_SEL  = BUS_AW'(OFS_SRCSEL);
  localparam logic [BUS_AW-1:0] A_CMD  = BUS_AW'(OFS_PCMD);
  localparam logic [BUS_AW-1:0] A_STAT = BUS_AW'(OFS_PSTAT);
  localparam int unsigned STAT_PAD = WORD_W - STAT_BUSY_BIT - 1;

  logic [1:0]          rst_pipe_q;
  logic                rst_sync_n;
  logic [RSTCTL_W-1:0] rstctl;
  logic [SRC_W-1:0]    srcsel;
  logic                launch;
  port_cmd_t           cmd;
  logic [WORD_W-1:0]   cmd_word;
  logic                xact_busy;
  logic [PORT_DW-1:0]  stat_data;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  cfgport_cfgregs #(
    .BUS_AW (BUS_AW),
    .SRC_W  (SRC_W)
  ) u_cfgregs (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .wr_i     (bus_wr_i),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i),
    .rstctl_o (rstctl),
    .srcsel_o (srcsel)
  );

  cfgport_cmdreg #(
    .BUS_AW (BUS_AW)
  ) u_cmdreg (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .wr_i       (bus_wr_i),
    .addr_i     (bus_addr_i),
    .go_i       (bus_wdata_i[CMD_GO_BIT]),
    .rd_i       (bus_wdata_i[CMD_RD_BIT]),
    .paddr_i    (bus_wdata_i[CMD_ADDR_LSB +: PORT_AW]),
    .pdata_i    (bus_wdata_i[PORT_DW-1:0]),
    .busy_i     (xact_busy),
    .launch_o   (launch),
    .cmd_o      (cmd),
    .cmd_word_o (cmd_word)
  );

  cfgport_xact u_xact (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .launch_i    (launch),
    .rd_i        (cmd.rd),
    .prt_rdy_i   (prt_rdy_i),
    .prt_rdata_i (prt_rdata_i),
    .busy_o      (xact_busy),
    .prt_en_o    (prt_en_o),
    .prt_we_o    (prt_we_o),
    .rdata_o     (stat_data)
  );

  // read mux
  always_comb begin
    unique case (bus_addr_i)
      A_RST:   bus_rdata_o = {{(WORD_W-RSTCTL_W){1'b0}}, rstctl};
      A_SEL:   bus_rdata_o = WORD_W'(srcsel);
      A_CMD:   bus_rdata_o = cmd_word;
      A_STAT:  bus_rdata_o = {{STAT_PAD{1'b0}}, xact_busy, stat_data};
      default: bus_rdata_o = '0;
    endcase
  end

  assign blk_rel_o   = rstctl[0];
  assign synth_en_o  = rstctl[1];
  assign src_sel_o   = srcsel;
  assign prt_addr_o  = cmd.addr;
  assign prt_wdata_o = cmd.data;

endmodule

// File: rtl/cfgport_bridge_chk.sv
module cfgport_bridge_chk
  import cfgport_pkg::*;
#(
  parameter int unsigned BUS_AW = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               bus_wr_i,
  input logic [BUS_AW-1:0]  bus_addr_i,
  input logic               go_i,
  input logic               busy_i,
  input logic               prt_en_i,
  input logic               prt_we_i,
  input logic               prt_rdy_i,
  input logic [PORT_AW-1:0] prt_addr_i,
  input logic [PORT_DW-1:0] prt_wdata_i,
  input logic [PORT_DW-1:0] stat_i
);

  localparam logic [BUS_AW-1:0] A_CMD = BUS_AW'(OFS_PCMD);

  // R4
  en_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prt_en_i |=> !prt_en_i);

  // R4
  we_with_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prt_we_i |-> prt_en_i);

  // R5
  busy_launch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(bus_wr_i && (bus_addr_i == A_CMD) && go_i));

  // R5
  busy_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && prt_rdy_i) |=> !busy_i);

  // R7
  cmd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> ($stable(prt_addr_i) && $stable(prt_wdata_i)));

  // R6
  stat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_i && prt_rdy_i) |=> $stable(stat_i));

endmodule

bind cfgport_bridge cfgport_bridge_chk #(.BUS_AW(BUS_AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_sync_n),
  .bus_wr_i    (bus_wr_i),
  .bus_addr_i  (bus_addr_i),
  .go_i        (bus_wdata_i[cfgport_pkg::CMD_GO_BIT]),
  .busy_i      (xact_busy),
  .prt_en_i    (prt_en_o),
  .prt_we_i    (prt_we_o),
  .prt_rdy_i   (prt_rdy_i),
  .prt_addr_i  (prt_addr_o),
  .prt_wdata_i (prt_wdata_o),
  .stat_i      (stat_data)
);

// File: tb/cfgport_bridge_bench.sv
module cfgport_bridge_bench;

  logic        clk;
  logic        rst_n;
  logic [7:0]  addr;
  logic        wr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        blk_rel, synth_en;
  logic [31:0] src_sel;
  logic [6:0]  prt_addr;
  logic [15:0] prt_wdata, prt_rdata;
  logic        prt_en, prt_we, prt_rdy;

  int n_tests = 0;
  int n_fail  = 0;
  int lat     = 1;
  int en_count;

  cfgport_bridge u_cfgport_bridge (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .bus_addr_i  (addr),
    .bus_wr_i    (wr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .blk_rel_o   (blk_rel),
    .synth_en_o  (synth_en),
    .src_sel_o   (src_sel),
    .prt_addr_o  (prt_addr),
    .prt_wdata_o (prt_wdata),
    .prt_rdata_i (prt_rdata),
    .prt_en_o    (prt_en),
    .prt_we_o    (prt_we),
    .prt_rdy_i   (prt_rdy)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // port responder: one ready per enable, lat cycles after it
  logic [15:0] mem [128];
  logic        pend;
  int          cnt;
  logic [6:0]  p_addr;
  logic        p_we;
  logic [15:0] p_wd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) mem[i] <= 16'h5A00 + 16'(i * 3);
      pend      <= 1'b0;
      cnt       <= 0;
      prt_rdy   <= 1'b0;
      prt_rdata <= '0;
      en_count  <= 0;
      p_addr    <= '0;
      p_we      <= 1'b0;
      p_wd      <= '0;
    end else begin
      prt_rdy <= 1'b0;
      if (prt_en) begin
        pend     <= 1'b1;
        cnt      <= lat;
        p_addr   <= prt_addr;
        p_we     <= prt_we;
        p_wd     <= prt_wdata;
        en_count <= en_count + 1;
      end else if (pend) begin
        if (cnt <= 1) begin
          prt_rdy <= 1'b1;
          pend    <= 1'b0;
          if (p_we) mem[p_addr] <= p_wd;
          else      prt_rdata <= mem[p_addr];
        end else begin
          cnt <= cnt - 1;
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr  = a;
    wr    = 1'b1;
    wdata = d;
    @(negedge clk);
    wr    = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  // counts busy-high samples, starting at the current negedge
  task automatic wait_idle(output int nbusy);
    logic [31:0] s;
    nbusy = 0;
    for (int k = 0; k < 1000; k++) begin
      bus_read(8'h74, s);
      if (!s[16]) break;
      nbusy++;
      @(negedge clk);
    end
  endtask

  task automatic port_read(input logic [6:0] pa, output logic [15:0] v);
    int n;
    logic [31:0] s;
    bus_write(8'h70, 32'h3000_0000 | (32'(pa) << 16));
    wait_idle(n);
    bus_read(8'h74, s);
    v = s[15:0];
  endtask

  task automatic t_reset;
    logic [31:0] v;
    bus_read(8'h40, v); chk("R1 rstctl", v, 0);
    bus_read(8'h44, v); chk("R1 srcsel", v, 0);
    bus_read(8'h70, v); chk("R1 cmd", v, 0);
    bus_read(8'h74, v); chk("R1 status", v, 0);
    chk("R1 outputs", {29'd0, blk_rel, synth_en, prt_en}, 0);
    chk("R1 src_sel", src_sel, 0);
  endtask

  task automatic t_rstctl;
    logic [31:0] v;
    bus_write(8'h40, 32'hFFFF_FFFF);
    bus_read(8'h40, v); chk("R2 readback all", v, 32'h3);
    chk("R2 outputs 11", {30'd0, synth_en, blk_rel}, 32'h3);
    bus_write(8'h40, 32'h0000_0002);
    bus_read(8'h40, v); chk("R2 readback 2", v, 32'h2);
    chk("R2 outputs 10", {30'd0, synth_en, blk_rel}, 32'h2);
  endtask

  task automatic t_srcsel;
    logic [31:0] v;
    bus_write(8'h44, 32'hDEAD_BEEF);
    bus_read(8'h44, v); chk("R3 readback", v, 32'hDEAD_BEEF);
    chk("R3 output", src_sel, 32'hDEAD_BEEF);
    bus_write(8'h44, 32'h0000_0001);
    bus_read(8'h44, v); chk("R3 readback 1", v, 32'h1);
  endtask

  task automatic t_port_write;
    logic [31:0] v;
    logic [15:0] r;
    int n, e0;
    lat = 1;
    e0 = en_count;
    bus_write(8'h70, 32'h2015_1234);
    chk("R4 en", {31'd0, prt_en}, 1);
    chk("R4 we", {31'd0, prt_we}, 1);
    chk("R4 addr", {25'd0, prt_addr}, 32'h15);
    chk("R4 wdata", {16'd0, prt_wdata}, 32'h1234);
    wait_idle(n);
    chk("R5 busy span L=1", n, 3);
    chk("R4 one enable", en_count - e0, 1);
    bus_read(8'h74, v); chk("R6 write leaves data", v, 0);
    bus_read(8'h70, v); chk("R10 cmd readback", v, 32'h2015_1234);
    port_read(7'h15, r);
    chk("R6 read back written", {16'd0, r}, 32'h1234);
  endtask

  task automatic t_port_read;
    logic [31:0] v;
    int n;
    lat = 4;
    bus_write(8'h70, 32'h304E_FFFF);
    chk("R4 read en", {31'd0, prt_en}, 1);
    chk("R4 read we low", {31'd0, prt_we}, 0);
    @(negedge clk);
    chk("R4 en single cycle", {31'd0, prt_en}, 0);
    wait_idle(n);
    chk("R5 busy span L=4", n, 5);
    bus_read(8'h74, v); chk("R6 read data", v, 32'h5AEA);
    bus_read(8'h70, v); chk("R10 read cmd readback", v, 32'h304E_FFFF);
  endtask

  task automatic t_busy_ignore;
    logic [31:0] v;
    logic [15:0] r;
    int n, e0;
    lat = 6;
    e0 = en_count;
    bus_write(8'h70, 32'h3010_0000);
    bus_write(8'h70, 32'h2020_BEEF);
    chk("R7 addr held", {25'd0, prt_addr}, 32'h10);
    chk("R7 wdata held", {16'd0, prt_wdata}, 0);
    wait_idle(n);
    chk("R7 single enable", en_count - e0, 1);
    bus_read(8'h74, v); chk("R7 first read result", v, 32'h5A30);
    bus_read(8'h70, v); chk("R7 cmd unchanged", v, 32'h3010_0000);
    lat = 2;
    port_read(7'h20, r);
    chk("R7 dropped write absent", {16'd0, r}, 32'h5A60);
  endtask

  task automatic t_nogo;
    logic [31:0] v;
    int e0;
    e0 = en_count;
    bus_read(8'h70, v);
    bus_write(8'h70, 32'h0033_5555);
    bus_read(8'h74, v); chk("R8 not busy", {31'd0, v[16]}, 0);
    @(negedge clk);
    chk("R8 no enable", en_count - e0, 0);
    bus_read(8'h70, v); chk("R8 cmd unchanged", v, 32'h3020_0000);
  endtask

  task automatic t_unlisted;
    logic [31:0] v;
    int e0;
    e0 = en_count;
    bus_write(8'h48, 32'hFFFF_FFFF);
    bus_write(8'h00, 32'hFFFF_FFFF);
    bus_write(8'h7C, 32'hFFFF_FFFF);
    bus_write(8'h72, 32'h2011_1111);
    bus_read(8'h48, v); chk("R9 0x48 zero", v, 0);
    bus_read(8'h00, v); chk("R9 0x00 zero", v, 0);
    bus_read(8'h7C, v); chk("R9 0x7C zero", v, 0);
    bus_read(8'h72, v); chk("R9 0x72 zero", v, 0);
    bus_read(8'h40, v); chk("R9 rstctl kept", v, 32'h2);
    bus_read(8'h44, v); chk("R9 srcsel kept", v, 32'h1);
    @(negedge clk);
    chk("R9 no enable", en_count - e0, 0);
  endtask

  initial begin
    #(200000 * 10);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    addr  = '0;
    wr    = 1'b0;
    wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_rstctl();
    t_srcsel();
    t_port_write();
    t_port_read();
    t_busy_ignore();
    t_nogo();
    t_unlisted();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule